// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two N-bit unsigned operands and a carry-in and returns an N-bit sum and a carry-out, all in combinational logic with no clock or storage. The carry chain is a parallel-prefix network. First, each bit produces a local generate and propagate pair, and the carry-in is placed below the lowest operand bit as an extra position. A tree of merge cells then forms, for every position, the generate of the span from that position down to the carry-in. Finally, an XOR stage forms each sum bit from its own propagate and the prefix generate of the position below it. A last merge at the top position gives the carry-out.

A compile-time parameter selects one of three tree wirings.
- A doubling-distance tree has the fewest levels and the lowest fanout, but uses the most cells and wires.
- A block-doubling tree has the same few levels, with high fanout at the block boundaries.
- A two-sweep tree first builds power-of-two spans and then fills in the missing prefixes. It uses about two cells per bit and nearly twice the levels.

All three produce identical results. Merge cells come in two kinds: a full kind that keeps both group signals, and a reduced kind that keeps only the group generate. The reduced kind is used wherever the lower span already reaches the carry-in. Positions that do nothing on a level pass through a buffer cell. The operands and the result are plain buses. There is no valid/ready pairing, because the path holds no state and so has no back-pressure to express.

Top module: `prefix_adder`

## Requirements
- R1: For every operand pair and carry-in, the output pair {cout, s} equals the (N+1)-bit value a + b + cin.
- R2: Sum bit 0 equals a[0] XOR b[0] XOR cin, because the carry-in enters as the lowest prefix position.
- R3: When every bit propagates (a XOR b is all ones), cout equals cin, and s is all ones when cin is 0 and all zeros when cin is 1.
- R4: When no bit generates (a AND b is zero), cout is 1 only if cin is 1 and every bit propagates; otherwise cout is 0.
- R5: When a[N-1] and b[N-1] are both 1, cout is 1. When both are 0, cout is 0.
- R6: The parameter TOPO selects the tree wiring: 0 for block-doubling, 1 for doubling-distance, 2 for two-sweep. Every legal value gives the same arithmetic result. Any other value, or an N that is not a power of two of at least 2, stops elaboration with an error.
- R7: The outputs depend only on the present inputs. A new input value is reflected in the outputs within the same clock period, with no clock edge in between.
- R8: At N = 32, R1 holds for every topology.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| s | output | N | Sum bits |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
The bench builds six instances at the same time: N = 16 and N = 32, each with all three values of TOPO. Every vector is therefore checked against the reference sum through every wiring and both depths. The 32-bit instances reach the deeper trees, including the nine-level two-sweep arrangement and fanout at the 16-bit block boundary, which a 16-bit build never exercises. Directed vectors cover full-width carry propagation, carry generated only at the top bit, and the no-generate case. A same-period test shows that the result does not wait for a clock edge.

// File: rtl/prefix_adder_pkg.sv
package prefix_adder_pkg;

  typedef enum logic [1:0] {
    PA_SKLANSKY    = 2'd0,
    PA_KOGGE_STONE = 2'd1,
    PA_BRENT_KUNG  = 2'd2
  } pa_topo_e;

  // True for 2, 4, 8, ...
  function automatic bit pa_is_pow2(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction

  // Number of merge levels for a tree over n positions.
  function automatic int pa_depth(input pa_topo_e t, input int n);
    int lg;
    lg = $clog2(n);
    if (t == PA_BRENT_KUNG) return 2 * lg - 1;
    return lg;
  endfunction

  // Index of the lower span merged into node i at level lvl (1-based);
  // -1 when the node only passes through a buffer.
  function automatic int pa_partner(input pa_topo_e t, input int n,
                                    input int lvl, input int i);
    int lg, blk, half;
    lg = $clog2(n);
    case (t)
      PA_KOGGE_STONE: begin
        half = 1 << (lvl - 1);
        return (i >= half) ? i - half : -1;
      end
      PA_SKLANSKY: begin
        blk  = 1 << lvl;
        half = blk >> 1;
        return ((i % blk) >= half) ? (i / blk) * blk + half - 1 : -1;
      end
      PA_BRENT_KUNG: begin
        if (lvl <= lg) begin
          blk = 1 << lvl;
          return (((i + 1) % blk) == 0) ? i - (blk >> 1) : -1;
        end
        blk  = 1 << (2 * lg - lvl);
        half = blk >> 1;
        return ((i >= blk) && ((i % blk) == half - 1)) ? i - half : -1;
      end
      default: return -1;
    endcase
  endfunction

  // True when the lower span merged into node i already reaches position 0,
  // so only the group generate is needed.
  function automatic bit pa_reaches_zero(input pa_topo_e t, input int n,
                                         input int lvl, input int i);
    int lg;
    lg = $clog2(n);
    case (t)
      PA_KOGGE_STONE: return i < (1 << lvl);
      PA_SKLANSKY:    return i < (1 << lvl);
      PA_BRENT_KUNG:  return (lvl > lg) ? 1'b1 : (i == (1 << lvl) - 1);
      default:        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pa_black_cell.sv
module pa_black_cell (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_out,
  output logic p_out
);
  assign g_out = g_hi | (p_hi & g_lo);
  assign p_out = p_hi & p_lo;
endmodule

// File: rtl/pa_gray_cell.sv
module pa_gray_cell (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  output logic g_out
);
  assign g_out = g_hi | (p_hi & g_lo);
endmodule

// File: rtl/pa_buffer_cell.sv
module pa_buffer_cell (
  input  logic g_in,
  input  logic p_in,
  output logic g_out,
  output logic p_out
);
  assign g_out = g_in;
  assign p_out = p_in;
endmodule

// File: rtl/pa_bitwise_pg.sv
// Position 0 carries cin (generate = cin, propagate = 0); position k holds
// operand bit k-1.
module pa_bitwise_pg #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N:0]   g_bit,
  output logic [N:0]   p_bit
);
  assign g_bit[0] = cin;   // R2
  assign p_bit[0] = 1'b0;

  for (genvar k = 1; k <= N; k++) begin : g_pos
    assign g_bit[k] = a[k-1] & b[k-1];
    assign p_bit[k] = a[k-1] ^ b[k-1];
  end
endmodule

// File: rtl/pa_prefix_tree.sv
// Produces g_pre[i] = group generate of span i:0 for every position.
module pa_prefix_tree
  import prefix_adder_pkg::*;
#(
  parameter int       N    = 16,
  parameter pa_topo_e TOPO = PA_KOGGE_STONE
) (
  input  logic [N-1:0] g_bit,
  input  logic [N-1:0] p_bit,
  output logic [N-1:0] g_pre
);
  localparam int DEPTH = pa_depth(TOPO, N);

  logic [DEPTH:0][N-1:0] g_lvl;
  logic [DEPTH:0][N-1:0] p_lvl;

  assign g_lvl[0] = g_bit;
  assign p_lvl[0] = p_bit;

  for (genvar lv = 1; lv <= DEPTH; lv++) begin : g_level
    for (genvar i = 0; i < N; i++) begin : g_node
      localparam int PART = pa_partner(TOPO, N, lv, i);
      localparam bit LOW0 = pa_reaches_zero(TOPO, N, lv, i);
      if (PART < 0) begin : g_buf
        pa_buffer_cell u_buf (
          .g_in  (g_lvl[lv-1][i]),
          .p_in  (p_lvl[lv-1][i]),
          .g_out (g_lvl[lv][i]),
          .p_out (p_lvl[lv][i])
        );
      end else if (LOW0) begin : g_gray
        pa_gray_cell u_gray (
          .g_hi  (g_lvl[lv-1][i]),
          .p_hi  (p_lvl[lv-1][i]),
          .g_lo  (g_lvl[lv-1][PART]),
          .g_out (g_lvl[lv][i])
        );
        // A span ending at position 0 never propagates (P0:0 = 0).
        assign p_lvl[lv][i] = 1'b0;
      end else begin : g_black
        pa_black_cell u_black (
          .g_hi  (g_lvl[lv-1][i]),
          .p_hi  (p_lvl[lv-1][i]),
          .g_lo  (g_lvl[lv-1][PART]),
          .p_lo  (p_lvl[lv-1][PART]),
          .g_out (g_lvl[lv][i]),
          .p_out (p_lvl[lv][i])
        );
      end
    end
  end

  assign g_pre = g_lvl[DEPTH];

  // Group propagate of prefix spans is not needed past the tree.
  logic unused_prop;
  assign unused_prop = ^p_lvl;
endmodule

// File: rtl/pa_sum_stage.sv
module pa_sum_stage #(
  parameter int N = 16
) (
  input  logic [N-1:0] p_op,    // operand-bit propagates, positions 1..N
  input  logic [N-1:0] g_pre,   // prefix generates, spans 0:0 .. N-1:0
  input  logic         g_top,   // generate at position N
  output logic [N-1:0] s,
  output logic         cout
);
  assign s = p_op ^ g_pre;

  // Final reduced merge forms GN:0.
  pa_gray_cell u_cout (
    .g_hi  (g_top),
    .p_hi  (p_op[N-1]),
    .g_lo  (g_pre[N-1]),
    .g_out (cout)
  );
endmodule

// File: rtl/prefix_adder.sv
module prefix_adder
  import prefix_adder_pkg::*;
#(
  parameter int       N    = 16,
  parameter pa_topo_e TOPO = PA_KOGGE_STONE
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] s,
  output logic         cout
);
  // R6: reject illegal widths and topology codes at elaboration.
  if (!pa_is_pow2(N)) begin : g_bad_width
    $error("prefix_adder: width N=%0d must be a power of two >= 2", N);
  end
  if (TOPO != PA_SKLANSKY && TOPO != PA_KOGGE_STONE && TOPO != PA_BRENT_KUNG)
  begin : g_bad_topo
    $error("prefix_adder: unsupported TOPO code %0d", TOPO);
  end

  logic [N:0]   g_bit;
  logic [N:0]   p_bit;
  logic [N-1:0] g_pre;

  pa_bitwise_pg #(.N(N)) u_pg (
    .a     (a),
    .b     (b),
    .cin   (cin),
    .g_bit (g_bit),
    .p_bit (p_bit)
  );

  pa_prefix_tree #(.N(N), .TOPO(TOPO)) u_tree (
    .g_bit (g_bit[N-1:0]),
    .p_bit (p_bit[N-1:0]),
    .g_pre (g_pre)
  );

  pa_sum_stage #(.N(N)) u_sum (
    .p_op  (p_bit[N:1]),
    .g_pre (g_pre),
    .g_top (g_bit[N]),
    .s     (s),
    .cout  (cout)
  );
endmodule

// File: rtl/prefix_adder_chk.sv
module prefix_adder_chk #(
  parameter int N = 16
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic         cin,
  input logic [N-1:0] s,
  input logic         cout
);
  logic [N:0] sum_ref;
  assign sum_ref = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};

  always_comb begin
    AST_SUM_EXACT: assert ({cout, s} == sum_ref); // R1
    AST_LSB_CIN: assert (s[0] == (a[0] ^ b[0] ^ cin)); // R2
    AST_FULL_PROPAGATE: assert (!(&(a ^ b)) || (cout == cin && s == {N{~cin}})); // R3
    AST_NO_GENERATE: assert (((a & b) != '0) || (cout == (cin & (&(a ^ b))))); // R4
    AST_TOP_GENERATE: assert (!(a[N-1] & b[N-1]) || cout); // R5
    AST_TOP_KILL: assert ((a[N-1] | b[N-1]) || !cout); // R5
  end
endmodule

bind prefix_adder prefix_adder_chk #(.N(N)) u_prefix_adder_chk (
  .a    (a),
  .b    (b),
  .cin  (cin),
  .s    (s),
  .cout (cout)
);

// File: tb/test_prefix_adder.sv
module test_prefix_adder;
  import prefix_adder_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [15:0] a16, b16;
  logic [31:0] a32, b32;
  logic        cin;

  logic [15:0] s16_sk, s16_ks, s16_bk;
  logic        c16_sk, c16_ks, c16_bk;
  logic [31:0] s32_sk, s32_ks, s32_bk;
  logic        c32_sk, c32_ks, c32_bk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  prefix_adder #(.N(16), .TOPO(PA_SKLANSKY)) i_prefix_adder_sk16 (
    .a(a16), .b(b16), .cin(cin), .s(s16_sk), .cout(c16_sk));
  prefix_adder #(.N(16), .TOPO(PA_KOGGE_STONE)) i_prefix_adder_ks16 (
    .a(a16), .b(b16), .cin(cin), .s(s16_ks), .cout(c16_ks));
  prefix_adder #(.N(16), .TOPO(PA_BRENT_KUNG)) i_prefix_adder_bk16 (
    .a(a16), .b(b16), .cin(cin), .s(s16_bk), .cout(c16_bk));
  prefix_adder #(.N(32), .TOPO(PA_SKLANSKY)) i_prefix_adder_sk32 (
    .a(a32), .b(b32), .cin(cin), .s(s32_sk), .cout(c32_sk));
  prefix_adder #(.N(32), .TOPO(PA_KOGGE_STONE)) i_prefix_adder_ks32 (
    .a(a32), .b(b32), .cin(cin), .s(s32_ks), .cout(c32_ks));
  prefix_adder #(.N(32), .TOPO(PA_BRENT_KUNG)) i_prefix_adder_bk32 (
    .a(a32), .b(b32), .cin(cin), .s(s32_bk), .cout(c32_bk));

  function automatic logic [16:0] ref16(input logic [15:0] x, y, input logic c);
    return {1'b0, x} + {1'b0, y} + {16'd0, c};
  endfunction

  function automatic logic [32:0] ref32(input logic [31:0] x, y, input logic c);
    return {1'b0, x} + {1'b0, y} + {32'd0, c};
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [32:0] act, input logic [32:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Full-result comparison on all six instances (R1, R6 per topology, R8 at 32 bits).
  task automatic check_full(input string tag);
    logic [16:0] e16;
    logic [32:0] e32;
    e16 = ref16(a16, b16, cin);
    e32 = ref32(a32, b32, cin);
    cmp({"R1 R6 ", tag}, "sk16", {16'd0, c16_sk, s16_sk}, {16'd0, e16});
    cmp({"R1 R6 ", tag}, "ks16", {16'd0, c16_ks, s16_ks}, {16'd0, e16});
    cmp({"R1 R6 ", tag}, "bk16", {16'd0, c16_bk, s16_bk}, {16'd0, e16});
    cmp({"R8 R6 ", tag}, "sk32", {c32_sk, s32_sk}, e32);
    cmp({"R8 R6 ", tag}, "ks32", {c32_ks, s32_ks}, e32);
    cmp({"R8 R6 ", tag}, "bk32", {c32_bk, s32_bk}, e32);
  endtask

  task automatic drive(input logic [31:0] x16, y16, x32, y32, input logic c);
    @(posedge clk);
    a16 <= x16[15:0];
    b16 <= y16[15:0];
    a32 <= x32;
    b32 <= y32;
    cin <= c;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    a16 = '0; b16 = '0; a32 = '0; b32 = '0; cin = 1'b0;
    void'($urandom(32'd20250713));

    // Idle / all zeros: everything zero (R1, R4).
    drive('0, '0, '0, '0, 1'b0);
    check_full("zeros");
    cmp("R4", "cout16 zeros", {32'd0, c16_bk}, 33'd0);

    // All ones plus cin: full-width carry, sum all ones (R1, R5).
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    check_full("ones_cin");
    cmp("R5", "cout32 top gen", {32'd0, c32_sk}, 33'd1);

    // Carry rippling across the whole width: all ones + 1.
    drive(32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFF, 32'd1, 1'b0);
    check_full("ripple_b");
    // Same, with the carry injected only through cin (R2, R3).
    drive(32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 32'd0, 1'b1);
    check_full("ripple_cin");
    cmp("R3", "s16 all-propagate cin=1", {17'd0, s16_ks}, 33'd0);
    cmp("R3", "cout32 all-propagate cin=1", {32'd0, c32_bk}, 33'd1);
    cmp("R2", "s16_sk[0]", {32'd0, s16_sk[0]}, 33'd0);

    // Alternating patterns: every bit propagates (R3).
    for (int c = 0; c < 2; c++) begin
      drive(32'hAAAA_AAAA, 32'h5555_5555, 32'h5555_5555, 32'hAAAA_AAAA, c[0]);
      check_full("alternate");
      cmp("R3", "cout16 equals cin", {32'd0, c16_sk}, {32'd0, c[0]});
      cmp("R3", "s32 all-propagate", {1'b0, s32_ks}, {1'b0, {32{~c[0]}}});
    end
    drive(32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'h5555_5555, 32'h5555_5555, 1'b1);
    check_full("alt_same");

    // No generating bit, not all propagating: cout must be 0 (R4).
    drive(32'h0F0F_0F00, 32'h0000_F0F0, 32'h0F0F_0000, 32'h0000_00F0, 1'b1);
    check_full("no_gen");
    cmp("R4", "cout16 no-gen", {32'd0, c16_ks}, 33'd0);
    cmp("R4", "cout32 no-gen", {32'd0, c32_ks}, 33'd0);

    // Carry generated only at the top bit (R5).
    drive(32'h8000_8000, 32'h8000_8000, 32'h8000_0000, 32'h8000_0000, 1'b0);
    check_full("top_gen");
    cmp("R5", "cout16 top gen", {32'd0, c16_bk}, 33'd1);
    cmp("R5", "cout32 top gen", {32'd0, c32_bk}, 33'd1);
    // Top bits both clear, lower half all ones: no carry out (R5).
    drive(32'h7FFF, 32'h7FFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1);
    check_full("top_kill");
    cmp("R5", "cout16 top kill", {32'd0, c16_sk}, 33'd0);
    cmp("R5", "cout32 top kill", {32'd0, c32_sk}, 33'd0);

    // Bit 0 depends on cin (R2).
    drive(32'd1, 32'd0, 32'd0, 32'd1, 1'b1);
    cmp("R2", "s16_ks[0]", {32'd0, s16_ks[0]}, 33'd0);
    cmp("R2", "s32_bk[0]", {32'd0, s32_bk[0]}, 33'd0);
    cmp("R2", "s16_bk[1]", {32'd0, s16_bk[1]}, 33'd1);

    // Same-period response, no clock edge between drive and sample (R7).
    @(posedge clk);
    #3;
    a16 = 16'h1234; b16 = 16'hEDCB; a32 = 32'hDEAD_BEEF; b32 = 32'h2152_4110; cin = 1'b1;
    #1;
    cmp("R7", "same-period bk16", {16'd0, c16_bk, s16_bk}, {16'd0, ref16(a16, b16, cin)});
    cmp("R7", "same-period ks32", {c32_ks, s32_ks}, ref32(a32, b32, cin));
    a16 = 16'h0001; b16 = 16'h0001; cin = 1'b0;
    #1;
    cmp("R7", "same-period sk16", {16'd0, c16_sk, s16_sk}, 33'd2);

    // Random vectors, a quarter of them biased toward long propagate runs.
    for (int v = 0; v < 10000; v++) begin
      logic [31:0] ra, rb, xa, xb;
      logic        rc;
      ra = $urandom;
      rb = $urandom;
      xa = $urandom;
      xb = $urandom;
      rc = 1'($urandom % 2);
      if ((v % 4) == 1) begin
        rb = ~ra ^ (32'd1 << ($urandom % 16));
        xb = ~xa ^ (32'd1 << ($urandom % 32));
      end
      drive(ra, rb, xa, xb, rc);
      check_full("random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule